// File: doc/BRIEF.md
# Dual-pulse up/down binary counter

The block is a binary counter with no direction bit. It counts from two separate pulse lines. A rising edge on the up line adds one and a rising edge on the down line subtracts one. Both lines idle high. A parallel load input (active low) and a master clear input set the count directly. Two active-low terminal flags, carry and borrow, are gated by the low phase of the matching pulse line. Because of this gating, a carry or borrow flag can drive the matching pulse input of the next, more significant instance with no glue logic.

All storage runs on one system clock. The two pulse lines, the clear, the load and the data bus pass through a shared synchroniser. Edges are found by comparing each synchronised line with its value one clock earlier. An input change therefore reaches the count three clock edges later: two synchroniser stages, then the count register. When both pulse lines are low at once, the counter holds its value and sets a sticky fault flag. The count width is a parameter and defaults to 4.

Top module: `updn_pulse_counter`

## Requirements
- R1: A rising edge on the up line adds one to the count, provided the down line is high in the cycle before the edge and in the cycle of the edge.
- R2: A rising edge on the down line subtracts one from the count, provided the up line is high in the cycle before the edge and in the cycle of the edge.
- R3: While both pulse lines are low, the count holds and fault_o goes high. fault_o stays high after the lines recover. If both lines rise together, no count takes place.
- R4: While clear_i is high, the count is zero and fault_o is low. This overrides load and both pulse lines.
- R5: While load_ni is low and clear_i is low, the count follows data_i.
- R6: carry_no is low exactly when the count is all ones and the up line is low. Otherwise it is high.
- R7: borrow_no is low exactly when the count is zero and the down line is low. Otherwise it is high.
- R8: Counting up from all ones gives zero. Counting down from zero gives all ones.
- R9: Pulse edges that arrive while load or clear is active are discarded. Releasing load or clear does not by itself cause a count.
- R10: Two instances chained carry-to-up and borrow-to-down form a counter of twice the width. Each carry or borrow moves the upper instance by one.
- R11: While rst_ni is low, the count is zero, fault_o is low, and both terminal flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_pulse_i | input | 1 | Count-up pulse line, idles high |
| dn_pulse_i | input | 1 | Count-down pulse line, idles high |
| load_ni | input | 1 | Parallel load, active low |
| clear_i | input | 1 | Master clear, active high |
| data_i | input | WIDTH | Value taken by the count during load |
| count_o | output | WIDTH | Current count |
| carry_no | output | 1 | Terminal count up, active low |
| borrow_no | output | 1 | Terminal count down, active low |
| fault_o | output | 1 | Sticky flag: both pulse lines were low together |

## Verification
Two instances are chained. The 8-bit result is followed through a table of loads and up and down pulses. The table crosses both wrap boundaries and the nibble boundary in each direction, so it separates a broken carry or borrow path from a broken count step. Directed tests do four further things. They hold each pulse line low at a terminal count to observe the flag levels. They pulse while load is active to show the edge is discarded. They raise clear together with load to check priority. They drive both lines low to show the count holding, the sticky fault flag, and that a joint release does not count.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_CLEAR,
    MODE_LOAD,
    MODE_FAULT,
    MODE_UP,
    MODE_DOWN
  } mode_e;
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int              WIDTH   = 8,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int NSTG = (STAGES < 1) ? 1 : STAGES;

  logic [WIDTH-1:0] stage_q [NSTG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSTG; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < NSTG; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[NSTG-1];
endmodule

// File: rtl/updn_edge.sv
module updn_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_s_i,
  input  logic dn_s_i,
  output logic up_step_o,
  output logic dn_step_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b1;
      dn_q <= 1'b1;
    end else begin
      up_q <= up_s_i;
      dn_q <= dn_s_i;
    end
  end

  // opposite line must be high on both sides of the edge
  assign up_step_o = up_s_i & ~up_q & dn_s_i & dn_q;
  assign dn_step_o = dn_s_i & ~dn_q & up_s_i & up_q;
endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic             up_s_i,
  input  logic             dn_s_i,
  input  logic             up_step_i,
  input  logic             dn_step_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             fault_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  mode_e            mode;
  logic [WIDTH-1:0] cnt_q;
  logic             fault_q;

  always_comb begin
    if (clr_i)                  mode = MODE_CLEAR;
    else if (!load_ni)          mode = MODE_LOAD;
    else if (!up_s_i && !dn_s_i) mode = MODE_FAULT;
    else if (up_step_i)         mode = MODE_UP;
    else if (dn_step_i)         mode = MODE_DOWN;
    else                        mode = MODE_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_CLEAR: begin
          cnt_q   <= '0;
          fault_q <= 1'b0;
        end
        MODE_LOAD:  cnt_q   <= data_i;
        MODE_FAULT: fault_q <= 1'b1;
        MODE_UP:    cnt_q   <= cnt_q + ONE;
        MODE_DOWN:  cnt_q   <= cnt_q - ONE;
        default:    ;
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_s_i,
  input  logic             dn_s_i,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam logic [WIDTH-1:0] TOP = '1;

  assign carry_no  = ~((cnt_i == TOP) & ~up_s_i);
  assign borrow_no = ~((cnt_i == '0)  & ~dn_s_i);
endmodule

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_pulse_i,
  input  logic             dn_pulse_i,
  input  logic             load_ni,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_no,
  output logic             borrow_no,
  output logic             fault_o
);
  localparam int             CW        = WIDTH + 4;
  localparam logic [CW-1:0]  CTRL_IDLE = {1'b0, 1'b1, 1'b1, 1'b1, {WIDTH{1'b0}}};

  logic [CW-1:0]    ctrl_raw, ctrl_s;
  logic             clr_s, load_ns, up_s, dn_s;
  logic [WIDTH-1:0] data_s;
  logic             up_step, dn_step;
  logic [WIDTH-1:0] cnt_q;
  logic             fault_q;

  assign ctrl_raw = {clear_i, load_ni, dn_pulse_i, up_pulse_i, data_i};

  updn_sync #(
    .WIDTH  (CW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTRL_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_raw),
    .q_o   (ctrl_s)
  );

  assign clr_s   = ctrl_s[CW-1];
  assign load_ns = ctrl_s[CW-2];
  assign dn_s    = ctrl_s[CW-3];
  assign up_s    = ctrl_s[CW-4];
  assign data_s  = ctrl_s[WIDTH-1:0];

  updn_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .up_s_i   (up_s),
    .dn_s_i   (dn_s),
    .up_step_o(up_step),
    .dn_step_o(dn_step)
  );

  updn_core #(.WIDTH(WIDTH)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_s),
    .load_ni  (load_ns),
    .up_s_i   (up_s),
    .dn_s_i   (dn_s),
    .up_step_i(up_step),
    .dn_step_i(dn_step),
    .data_i   (data_s),
    .cnt_o    (cnt_q),
    .fault_o  (fault_q)
  );

  updn_term #(.WIDTH(WIDTH)) u_term (
    .cnt_i    (cnt_q),
    .up_s_i   (up_s),
    .dn_s_i   (dn_s),
    .carry_no (carry_no),
    .borrow_no(borrow_no)
  );

  assign count_o = cnt_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/updn_checker.sv
module updn_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_s,
  input logic             load_ns,
  input logic             up_s,
  input logic             dn_s,
  input logic [WIDTH-1:0] data_s,
  input logic [WIDTH-1:0] cnt,
  input logic             borrow_n,
  input logic             fault
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> (cnt == '0 && !fault));

  a_r5_load_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && !load_ns) |=> (cnt == $past(data_s)));

  a_r3_fault_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && load_ns && !up_s && !dn_s) |=> ($stable(cnt) && fault));

  a_r3_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault && !clr_s) |=> fault);

  a_r1_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && load_ns) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

  a_r7_borrow_needs_dn_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_n |-> !dn_s);
endmodule

bind updn_pulse_counter updn_checker #(.WIDTH(WIDTH)) i_updn_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_s   (clr_s),
  .load_ns (load_ns),
  .up_s    (up_s),
  .dn_s    (dn_s),
  .data_s  (data_s),
  .cnt     (cnt_q),
  .borrow_n(borrow_no),
  .fault   (fault_q)
);

// File: tb/test_updn_pulse_counter.sv
module test_updn_pulse_counter;
  localparam int NVEC = 13;
  localparam logic [1:0] OP_LOAD = 2'd0, OP_UP = 2'd1, OP_DN = 2'd2;
  // {op, data, expected 8-bit cascade count}
  localparam logic [17:0] VEC [NVEC] = '{
    {OP_LOAD, 8'hFD, 8'hFD},
    {OP_UP,   8'h00, 8'hFE},
    {OP_UP,   8'h00, 8'hFF},
    {OP_UP,   8'h00, 8'h00},
    {OP_UP,   8'h00, 8'h01},
    {OP_DN,   8'h00, 8'h00},
    {OP_DN,   8'h00, 8'hFF},
    {OP_DN,   8'h00, 8'hFE},
    {OP_LOAD, 8'h0F, 8'h0F},
    {OP_UP,   8'h00, 8'h10},
    {OP_DN,   8'h00, 8'h0F},
    {OP_LOAD, 8'h30, 8'h30},
    {OP_DN,   8'h00, 8'h2F}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_r = 1'b1, dn_r = 1'b1, load_nr = 1'b1, clr_r = 1'b0;
  logic [7:0] data_r = '0;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_carry, lo_borrow, lo_fault;
  logic       hi_carry, hi_borrow, hi_fault;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  updn_pulse_counter i_updn_pulse_counter (
    .clk_i(clk), .rst_ni(rst_n), .up_pulse_i(up_r), .dn_pulse_i(dn_r),
    .load_ni(load_nr), .clear_i(clr_r), .data_i(data_r[3:0]),
    .count_o(lo_cnt), .carry_no(lo_carry), .borrow_no(lo_borrow), .fault_o(lo_fault)
  );

  updn_pulse_counter i_updn_pulse_counter_hi (
    .clk_i(clk), .rst_ni(rst_n), .up_pulse_i(lo_carry), .dn_pulse_i(lo_borrow),
    .load_ni(load_nr), .clear_i(clr_r), .data_i(data_r[7:4]),
    .count_o(hi_cnt), .carry_no(hi_carry), .borrow_no(hi_borrow), .fault_o(hi_fault)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_up();
    up_r = 1'b0; tick(6); up_r = 1'b1; tick(10);
  endtask

  task automatic pulse_dn();
    dn_r = 1'b0; tick(6); dn_r = 1'b1; tick(10);
  endtask

  task automatic do_load(logic [7:0] d);
    data_r = d; load_nr = 1'b0; tick(6); load_nr = 1'b1; tick(6);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(2);
    // R11: values under reset
    check("R11 count in reset", {hi_cnt, lo_cnt}, 8'h00);
    check("R11 flags in reset", {lo_carry, lo_borrow, lo_fault}, 3'b110);
    rst_n = 1'b1;
    tick(4);
    check("R11 state after reset", {hi_cnt, lo_cnt, lo_carry, lo_borrow, hi_fault}, 11'b00000000110);

    // R1 R2 R5 R8 R10: table of cascade operations
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][17:16])
        OP_LOAD: do_load(VEC[i][15:8]);
        OP_UP:   pulse_up();
        default: pulse_dn();
      endcase
      check($sformatf("R1/R2/R5/R8/R10 vector %0d", i), {hi_cnt, lo_cnt}, VEC[i][7:0]);
    end

    // R6: carry low only while count is all ones and up line low
    do_load(8'h0F);
    up_r = 1'b0; tick(4);
    check("R6 carry low at top", lo_carry, 1'b0);
    check("R6 upper unchanged while carry low", hi_cnt, 4'h0);
    up_r = 1'b1; tick(10);
    check("R6 carry released", lo_carry, 1'b1);
    check("R10 carry into upper", {hi_cnt, lo_cnt}, 8'h10);

    // R7: borrow low only while count is zero and down line low
    dn_r = 1'b0; tick(4);
    check("R7 borrow low at zero", lo_borrow, 1'b0);
    dn_r = 1'b1; tick(10);
    check("R7 borrow released", lo_borrow, 1'b1);
    check("R10 borrow into upper", {hi_cnt, lo_cnt}, 8'h0F);

    // R9: edges during load discarded; release does not count
    data_r = 8'h55; load_nr = 1'b0; tick(4);
    up_r = 1'b0; tick(4); up_r = 1'b1; tick(4);
    load_nr = 1'b1; tick(10);
    check("R9 edge under load ignored", {hi_cnt, lo_cnt}, 8'h55);
    pulse_up();
    check("R9 counting resumes", {hi_cnt, lo_cnt}, 8'h56);

    // R4: clear beats load
    data_r = 8'hAA; load_nr = 1'b0; clr_r = 1'b1; tick(6);
    check("R4 clear overrides load", {hi_cnt, lo_cnt}, 8'h00);
    clr_r = 1'b0; load_nr = 1'b1; tick(6);
    check("R4 zero after clear", {hi_cnt, lo_cnt}, 8'h00);

    // R3: both lines low
    do_load(8'h05);
    up_r = 1'b0; dn_r = 1'b0; tick(6);
    check("R3 fault raised", lo_fault, 1'b1);
    check("R3 count held", {hi_cnt, lo_cnt}, 8'h05);
    up_r = 1'b1; dn_r = 1'b1; tick(10);
    check("R3 fault sticky, joint release no count", {lo_fault, hi_cnt, lo_cnt}, 9'h105);
    pulse_up();
    check("R3 counting after fault", {hi_cnt, lo_cnt}, 8'h06);
    clr_r = 1'b1; tick(6); clr_r = 1'b0; tick(6);
    check("R4 clear resets fault", {lo_fault, hi_cnt, lo_cnt}, 9'h000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule